// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer N = B·P + A. It emits a single-cycle pulse once per N input cycles. A loop that compares a reference against a divided-down oscillator uses this pulse as its feedback input. The block is built from three parts. A dual-modulus prescaler counts input cycles modulo P+1 or modulo P. A swallow counter keeps the prescaler in its longer mode. A main counter sets the length of the whole period.

At the start of each period the swallow counter is loaded with A and the main counter with B. Each completed prescaler cycle decrements both counters. While the swallow counter is nonzero, every prescaler cycle lasts P+1 input cycles. Once it reaches zero, the remaining B−A prescaler cycles last P input cycles each. The period therefore totals A·(P+1) + (B−A)·P = B·P + A.

New settings arrive through a load strobe. Each load is checked for validity and held in a shadow register, so a running period always completes with the settings it started with.

Top module: `pswallow_divider`

## Requirements
- R1: The number of input clock cycles from one output pulse to the next equals B·P + A for the active settings.
- R2: `div_pulse` is high for exactly one input cycle per period, and that cycle is the final cycle of the period.
- R3: Within a period, each of the first A prescaler cycles spans P+1 input cycles and each of the remaining prescaler cycles spans P input cycles. The swallow count always stays below the main count.
- R4: While reset is held, `div_pulse` and `cfg_err` are low. After reset, the parameter default settings are active, and the first pulse appears in the (N−1)th cycle after the cycle in which reset is released.
- R5: A = 0 is valid. In that case the prescaler runs in divide-by-P mode for the whole period, and N = B·P.
- R6: A = B−1, the largest accepted swallow value, gives N = B·P + B − 1.
- R7: A valid load takes effect at the first period end after the load cycle. The period in progress keeps its original length.
- R8: A load is rejected when B ≤ A (compared as unsigned numbers) or when P = 0. After a rejected load, `cfg_err` reads 1 from the next cycle on, and the active and pending settings remain unchanged.
- R9: `cfg_err` is cleared by the next valid load.
- R10: When several valid loads occur within one period, only the last one is applied at the period end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Strobe that offers new settings |
| cfg_p | input | P_W | Prescaler base modulus P |
| cfg_a | input | A_W | Swallow count A |
| cfg_b | input | B_W | Main count B |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| cfg_err | output | 1 | Set when the most recent load was rejected |

## Verification
The bench builds the divider with 3-bit P and A fields and a 5-bit B field. With these widths the longest period is 224 cycles, so dozens of random settings can each be measured across both the changeover period and the following period. The small fields also put the edge cases within reach of ordinary random draws: P = 1 (prescaler toggling between divide-by-1 and divide-by-2), A = 0, A = B−1, and the largest A the field can hold. The maximum values of all three fields are also applied directly.

// File: rtl/pswallow_pkg.sv
// Package: shared types for the pulse-swallow divider.
// Holds the prescaler mode encoding used between the counters and the prescaler.
package pswallow_pkg;

    // Prescaler modulus selection: long (P+1) while swallowing, short (P) afterwards
    typedef enum logic {
        MOD_LONG  = 1'b0,
        MOD_SHORT = 1'b1
    } psc_mode_e;

endpackage

// File: rtl/pswallow_cfg.sv
// Module: pswallow_cfg
// Validates offered settings, keeps them in a pending register, and moves the
// pending settings into the active register at each period end.
// Assumes that the default parameters form a valid setting (P != 0, B > A).
module pswallow_cfg #(
    parameter int P_W   = 4,
    parameter int A_W   = 4,
    parameter int B_W   = 8,
    parameter int DEF_P = 8,
    parameter int DEF_A = 3,
    parameter int DEF_B = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [P_W-1:0] in_p,
    input  logic [A_W-1:0] in_a,
    input  logic [B_W-1:0] in_b,
    input  logic           apply,
    output logic [P_W-1:0] act_p,
    output logic [P_W-1:0] nxt_p,
    output logic [A_W-1:0] nxt_a,
    output logic [B_W-1:0] nxt_b,
    output logic           err
);
    localparam int CMP_W = (A_W > B_W) ? A_W : B_W;

    logic [CMP_W-1:0] a_ext, b_ext, act_a_ext, act_b_ext;
    logic             in_ok;
    logic [P_W-1:0]   pend_p;
    logic [A_W-1:0]   pend_a, act_a;
    logic [B_W-1:0]   pend_b, act_b;
    logic             pend_vld;

    // Decide whether the offered setting is legal
    always_comb begin
        a_ext = CMP_W'(in_a);
        b_ext = CMP_W'(in_b);
        in_ok = (in_p != '0) && (b_ext > a_ext);
    end

    // Settings to be used at the next period end
    always_comb begin
        nxt_p = pend_vld ? pend_p : act_p;
        nxt_a = pend_vld ? pend_a : act_a;
        nxt_b = pend_vld ? pend_b : act_b;
    end

    // Pending register: the last valid load wins until a period end consumes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_p   <= '0;
            pend_a   <= '0;
            pend_b   <= '0;
        end else if (load && in_ok) begin
            pend_vld <= 1'b1;
            pend_p   <= in_p;
            pend_a   <= in_a;
            pend_b   <= in_b;
        end else if (apply) begin
            pend_vld <= 1'b0;
        end
    end

    // Active register: changes only at a period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_p <= P_W'(DEF_P);
            act_a <= A_W'(DEF_A);
            act_b <= B_W'(DEF_B);
        end else if (apply) begin
            act_p <= nxt_p;
            act_a <= nxt_a;
            act_b <= nxt_b;
        end
    end

    // Error flag: reflects the outcome of the most recent load
    always_ff @(posedge clk) begin
        if (!rst_n)    err <= 1'b0;
        else if (load) err <= !in_ok;
    end

    assign act_a_ext = CMP_W'(act_a);
    assign act_b_ext = CMP_W'(act_b);

    AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (act_b_ext > act_a_ext) && (act_p != '0)); // R8
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_p) && $stable(act_a) && $stable(act_b))); // R7
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !in_ok && !apply) |=> (err && $stable(pend_vld) && $stable(pend_p)
                                         && $stable(pend_a) && $stable(pend_b))); // R8
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_ok) |=> !err); // R9
endmodule

// File: rtl/pswallow_prescaler.sv
// Module: pswallow_prescaler
// Dual-modulus prescaler running synchronously on the fast clock. It produces a
// tick on the last input cycle of each prescaler cycle.
// Assumes p_val != 0 and that mode or p_val change only on a tick edge.
module pswallow_prescaler
    import pswallow_pkg::*;
#(
    parameter int P_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] p_val,
    input  psc_mode_e      mode,
    output logic           tick
);
    localparam int PC_W = P_W + 1;

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] last;

    // Terminal count: P in long mode, P-1 in short mode
    always_comb begin
        if (mode == MOD_LONG) last = PC_W'(p_val);
        else                  last = PC_W'(p_val) - PC_W'(1);
        tick = (pc == last);
    end

    // Input-cycle counter within the current prescaler cycle
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= '0;
        else if (tick) pc <= '0;
        else           pc <= pc + PC_W'(1);
    end

    AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= last); // R3
endmodule

// File: rtl/pswallow_counters.sv
// Module: pswallow_counters
// Swallow (A) and main (B) down-counters, stepped by prescaler ticks. A period
// ends when B completes its last tick, and both counters then reload.
// Assumes that the reload values satisfy B > A.
module pswallow_counters
    import pswallow_pkg::*;
#(
    parameter int A_W   = 4,
    parameter int B_W   = 8,
    parameter int DEF_A = 3,
    parameter int DEF_B = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [A_W-1:0] ld_a,
    input  logic [B_W-1:0] ld_b,
    output psc_mode_e      mode,
    output logic           timeout
);
    localparam int CMP_W = (A_W > B_W) ? A_W : B_W;

    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;

    // Period end and prescaler mode from counter state
    always_comb begin
        timeout = tick && (b_cnt == B_W'(1));
        mode    = (a_cnt != '0) ? MOD_LONG : MOD_SHORT;
    end

    // Count down once per prescaler tick and reload at the period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt <= A_W'(DEF_A);
            b_cnt <= B_W'(DEF_B);
        end else if (timeout) begin
            a_cnt <= ld_a;
            b_cnt <= ld_b;
        end else if (tick) begin
            b_cnt <= b_cnt - B_W'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
        end
    end

    AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(a_cnt) < CMP_W'(b_cnt)); // R3
    AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt != '0); // R1
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> (a_cnt == $past(ld_a)) && (b_cnt == $past(ld_b))); // R7
    AST_SWALLOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !timeout && (a_cnt != '0)) |=> (a_cnt == $past(a_cnt) - A_W'(1))); // R3
endmodule

// File: rtl/pswallow_divider.sv
// Module: pswallow_divider (top)
// Divides clk by B*P + A and emits a one-cycle pulse on the last cycle of each period.
// Built from a settings shadow, a dual-modulus prescaler and swallow/main counters.
// Assumes A_W <= B_W is not required; the comparison widths are derived internally.
module pswallow_divider
    import pswallow_pkg::*;
#(
    parameter int P_W   = 4,
    parameter int A_W   = 4,
    parameter int B_W   = 8,
    parameter int DEF_P = 8,
    parameter int DEF_A = 3,
    parameter int DEF_B = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [P_W-1:0] cfg_p,
    input  logic [A_W-1:0] cfg_a,
    input  logic [B_W-1:0] cfg_b,
    output logic           div_pulse,
    output logic           cfg_err
);
    logic [P_W-1:0] act_p, nxt_p;
    logic [A_W-1:0] nxt_a;
    logic [B_W-1:0] nxt_b;
    psc_mode_e      mode;
    logic           tick;
    logic           timeout;

    pswallow_cfg #(
        .P_W(P_W), .A_W(A_W), .B_W(B_W),
        .DEF_P(DEF_P), .DEF_A(DEF_A), .DEF_B(DEF_B)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .load(cfg_load), .in_p(cfg_p), .in_a(cfg_a), .in_b(cfg_b),
        .apply(timeout),
        .act_p(act_p), .nxt_p(nxt_p), .nxt_a(nxt_a), .nxt_b(nxt_b),
        .err(cfg_err)
    );

    pswallow_prescaler #(.P_W(P_W)) u_psc (
        .clk(clk), .rst_n(rst_n),
        .p_val(act_p), .mode(mode), .tick(tick)
    );

    pswallow_counters #(
        .A_W(A_W), .B_W(B_W), .DEF_A(DEF_A), .DEF_B(DEF_B)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ld_a(nxt_a), .ld_b(nxt_b),
        .mode(mode), .timeout(timeout)
    );

    assign div_pulse = timeout;

    AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |-> tick); // R2
endmodule

// File: tb/tb_pswallow_divider.sv
module tb_pswallow_divider;
    localparam int TP_W = 3;
    localparam int TA_W = 3;
    localparam int TB_W = 5;
    localparam int D_P  = 5;
    localparam int D_A  = 2;
    localparam int D_B  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic [TP_W-1:0] cfg_p = '0;
    logic [TA_W-1:0] cfg_a = '0;
    logic [TB_W-1:0] cfg_b = '0;
    logic            div_pulse;
    logic            cfg_err;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int cur_n;

    always #4 clk = ~clk;

    pswallow_divider #(
        .P_W(TP_W), .A_W(TA_W), .B_W(TB_W),
        .DEF_P(D_P), .DEF_A(D_A), .DEF_B(D_B)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_p(cfg_p), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    function automatic int exp_n(input int p, input int a, input int b);
        return b * p + a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count cycles until the next pulse; optionally offer a setting in the first cycle
    task automatic run_period(input bit do_load, input int p, input int a, input int b,
                              output int n, output bit err_s);
        int c = 0;
        err_s = 1'b0;
        forever begin
            @(negedge clk);
            c++;
            cfg_load = 1'b0;
            if (c == 2) err_s = cfg_err;
            if (div_pulse) break;
            if (c == 1 && do_load) begin
                cfg_p    = TP_W'(p);
                cfg_a    = TA_W'(a);
                cfg_b    = TB_W'(b);
                cfg_load = 1'b1;
            end
        end
        cfg_load = 1'b0;
        n = c;
    endtask

    // Valid reconfiguration: old length first (R7), then new length (R1)
    task automatic reconfig(input string req, input int p, input int a, input int b);
        int  n;
        bit  e;
        run_period(1'b1, p, a, b, n, e);
        check("R7 period in progress keeps length", n, cur_n);
        check("R9 valid load leaves error low", int'(e), 0);
        cur_n = exp_n(p, a, b);
        run_period(1'b0, 0, 0, 0, n, e);
        check(req, n, cur_n);
    endtask

    // Invalid load: length unchanged and error raised
    task automatic bad_load(input int p, input int a, input int b);
        int n;
        bit e;
        run_period(1'b1, p, a, b, n, e);
        check("R8 rejected load, current period", n, cur_n);
        check("R8 cfg_err after rejected load", int'(e), 1);
        run_period(1'b0, 0, 0, 0, n, e);
        check("R8 rejected load, next period", n, cur_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit e;
        int amax;
        int p, a, b;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd8675309);

        // R4: reset state
        repeat (3) @(negedge clk);
        check("R4 div_pulse low in reset", int'(div_pulse), 0);
        check("R4 cfg_err low in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        cur_n = exp_n(D_P, D_A, D_B);
        run_period(1'b0, 0, 0, 0, n, e);
        check("R4 first pulse after reset", n, cur_n - 1);
        run_period(1'b0, 0, 0, 0, n, e);
        check("R1 default period", n, cur_n);
        run_period(1'b0, 0, 0, 0, n, e);
        check("R2 single pulse per period", n, cur_n);

        // Directed corners
        reconfig("R5 A=0 period", 3, 0, 5);
        reconfig("R6 A=B-1 period", 4, 6, 7);
        reconfig("R3 P=1 toggling prescaler", 1, 1, 3);
        reconfig("R1 largest fields", 7, 7, 31);
        reconfig("R6 A=B-1 small B", 2, 1, 2);

        // R8: rejected settings
        bad_load(3, 5, 5);
        bad_load(3, 6, 2);
        bad_load(0, 1, 3);
        reconfig("R9 recovery after error", 6, 3, 9);

        // R10: two loads in one period, the second must win
        begin
            int c;
            @(negedge clk);
            cfg_p = 3'd3; cfg_a = 3'd1; cfg_b = 5'd4; cfg_load = 1'b1;
            @(negedge clk);
            cfg_p = 3'd2; cfg_a = 3'd0; cfg_b = 5'd3; cfg_load = 1'b1;
            @(negedge clk);
            cfg_load = 1'b0;
            c = 3;
            while (!div_pulse) begin
                @(negedge clk);
                c++;
            end
            check("R10 period with two loads", c, cur_n);
            cur_n = exp_n(2, 0, 3);
            run_period(1'b0, 0, 0, 0, n, e);
            check("R10 last load applied", n, cur_n);
        end

        // Constrained random settings
        for (int i = 0; i < 30; i++) begin
            p    = $urandom_range(7, 1);
            b    = $urandom_range(31, 2);
            amax = (b - 1 < 7) ? b - 1 : 7;
            a    = $urandom_range(amax, 0);
            reconfig("R1 random setting", p, a, b);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule